// File: doc/BRIEF.md
# Coherent Byte-Access Capture/Compare Register

This block holds the 16-bit value of one timer channel and exposes it to an 8-bit bus as a high byte and a low byte. In capture mode the register takes the free-running counter value whenever a capture event arrives. In compare mode it holds the match value that the rest of the channel compares against. Because software needs two bus accesses to see all 16 bits, a read snapshot keeps the two halves consistent. The first byte read freezes a copy of the whole value, and the second byte comes from that copy, even if captures land between the two reads.

Writes in compare mode go into a byte-wide staging buffer. The live register changes only when both bytes have been staged and the commit input is asserted. A debug-halt input freezes the snapshot state. While it is high, bus reads see the live register directly and leave the snapshot alone, so an interrupted two-byte read can finish correctly after the halt ends. A write to the channel's status/control register drops the snapshot in any state.

Top module: `cap_cmp_reg`

## Requirements
- R1: After reset the live value, the read snapshot and the write staging buffer are all zero. Reads of either byte return 0x00 and `chanValue` is 0x0000.
- R2: In capture mode (`captureMode`=1), a cycle with `captureStrobe`=1 loads `counterValue` into the live value, which is visible on `chanValue` in the next cycle.
- R3: In capture mode without debug-halt, a read of either byte while no snapshot is held copies the whole live value into the snapshot and returns the live byte. `busSel`=1 selects the high byte and `busSel`=0 the low byte. Later reads return snapshot bytes, including repeated reads of the first byte. The first read of the other byte returns its snapshot byte and releases the snapshot. This holds for low-then-high and for high-then-low order.
- R4: A capture while a snapshot is held updates the live value (`chanValue`) but leaves the snapshot unchanged.
- R5: `ctrlWr`=1 releases the snapshot, also while debug-halt is active. When `ctrlWr` and a byte read fall in the same cycle, the snapshot ends up released.
- R6: In capture mode, bus writes to either byte have no effect on the live value, even when followed by `loadEn`.
- R7: While `dbgHalt`=1, byte reads neither take nor release a snapshot. A snapshot held on entry is still held, with its contents, after the halt ends.
- R8: While `dbgHalt`=1, reads return the live value's bytes, bypassing any held snapshot.
- R9: In compare mode (`captureMode`=0), a byte write goes only to the staging buffer and leaves `chanValue` unchanged.
- R10: In compare mode, `loadEn`=1 copies the staged 16-bit value into the live value (visible the next cycle) only after both bytes have been written since the last commit, in either order. With only one byte staged, `loadEn` has no effect.
- R11: In compare mode, reads return the live value's bytes and take no snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| captureMode | input | 1 | 1 = capture mode, 0 = compare mode |
| captureStrobe | input | 1 | Capture event, loads the counter value in capture mode |
| counterValue | input | 16 | Current timer counter value |
| busSel | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| busRd | input | 1 | Byte read strobe |
| busWr | input | 1 | Byte write strobe |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte, valid in the cycle of `busRd` |
| ctrlWr | input | 1 | Status/control register write strobe, releases the snapshot |
| dbgHalt | input | 1 | Debug halt: freezes the snapshot state, reads bypass it |
| loadEn | input | 1 | Commit enable for the staged compare value |
| chanValue | output | 16 | Live channel value |

## Verification
Two-byte reads are tried in both orders, with a capture between the halves. These cases show whether the second byte comes from the snapshot or from the live register. Repeating the first byte checks that it does not release the snapshot. Read sequences that cross a debug halt, with reads inside it, show both that reads during the halt bypass the snapshot and that the snapshot outlives the halt. A control write, alone, during a halt, and in the same cycle as a read, is checked by whether the next read returns fresh data. Compare-mode writes in both byte orders, with premature commits, show that a commit needs both bytes staged.

// File: rtl/cap_cmp_pkg.sv
package cap_cmp_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic       armLatch;   // copy live value into read snapshot
    logic       selBuffer;  // read mux selects snapshot
    logic       captureEn;  // load counter value into live register
    logic       commit;     // load staged value into live register
    logic [1:0] wrLane;     // stage write byte, [1] = high, [0] = low
  } chanStrobes_t;
endpackage

// File: rtl/cap_cmp_ctrl.sv
module cap_cmp_ctrl
  import cap_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         captureMode,
  input  logic         captureStrobe,
  input  logic         busSel,
  input  logic         busRd,
  input  logic         busWr,
  input  logic         ctrlWr,
  input  logic         dbgHalt,
  input  logic         loadEn,
  output chanStrobes_t strb,
  output logic         latchArmed
);
  localparam int LANES = 2;

  logic             armed;
  logic             firstSel;
  logic [LANES-1:0] laneSeen;
  logic             latchLive;
  logic             armNow;
  logic             relNow;
  logic             wrEn;
  logic             commitNow;
  logic [LANES-1:0] wrLaneNow;

  // Snapshot logic is active only in capture mode outside debug halt
  assign latchLive = captureMode & ~dbgHalt;
  assign armNow    = latchLive & busRd & ~armed & ~ctrlWr;
  assign relNow    = ctrlWr | (latchLive & busRd & armed & (busSel != firstSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      firstSel <= 1'b0;
    end else if (relNow) begin
      armed    <= 1'b0;
    end else if (armNow) begin
      armed    <= 1'b1;
      firstSel <= busSel;
    end
  end

  // Compare-mode write staging
  assign wrEn      = busWr & ~captureMode;
  assign wrLaneNow = {wrEn & busSel, wrEn & ~busSel};
  assign commitNow = loadEn & ~captureMode & (&laneSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneSeen <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (wrLaneNow[i])   laneSeen[i] <= 1'b1;
        else if (commitNow) laneSeen[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.armLatch  = armNow;
    strb.selBuffer = latchLive & armed;
    strb.captureEn = captureMode & captureStrobe;
    strb.commit    = commitNow;
    strb.wrLane    = wrLaneNow;
  end

  assign latchArmed = armed;
endmodule

// File: rtl/cap_cmp_dp.sv
module cap_cmp_dp
  import cap_cmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanStrobes_t          strb,
  input  logic                  busSel,
  input  logic [BYTE_W-1:0]     busWdata,
  input  logic [2*BYTE_W-1:0]   counterValue,
  output logic [BYTE_W-1:0]     busRdata,
  output logic [2*BYTE_W-1:0]   liveVal,
  output logic [2*BYTE_W-1:0]   wrBufVal
);
  localparam int LANES = 2;
  localparam int VAL_W = LANES * BYTE_W;

  logic [VAL_W-1:0]  readBuf;
  logic [BYTE_W-1:0] rdLane [LANES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveVal <= '0;
    end else if (strb.captureEn) begin
      liveVal <= counterValue;
    end else if (strb.commit) begin
      liveVal <= wrBufVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBuf <= '0;
    end else if (strb.armLatch) begin
      readBuf <= liveVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBufVal <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (strb.wrLane[i]) wrBufVal[i*BYTE_W +: BYTE_W] <= busWdata;
      end
    end
  end

  // Per-lane read source: snapshot or live register
  for (genvar g = 0; g < LANES; g++) begin : g_rdLane
    assign rdLane[g] = strb.selBuffer ? readBuf[g*BYTE_W +: BYTE_W]
                                      : liveVal[g*BYTE_W +: BYTE_W];
  end

  assign busRdata = busSel ? rdLane[1] : rdLane[0];
endmodule

// File: rtl/cap_cmp_reg.sv
module cap_cmp_reg
  import cap_cmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                captureMode,
  input  logic                captureStrobe,
  input  logic [2*BYTE_W-1:0] counterValue,
  input  logic                busSel,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  logic                ctrlWr,
  input  logic                dbgHalt,
  input  logic                loadEn,
  output logic [2*BYTE_W-1:0] chanValue
);
  localparam int VAL_W = 2 * BYTE_W;

  chanStrobes_t     strb;
  logic             latchArmed;
  logic [VAL_W-1:0] wrBufVal;

  cap_cmp_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .captureMode   (captureMode),
    .captureStrobe (captureStrobe),
    .busSel        (busSel),
    .busRd         (busRd),
    .busWr         (busWr),
    .ctrlWr        (ctrlWr),
    .dbgHalt       (dbgHalt),
    .loadEn        (loadEn),
    .strb          (strb),
    .latchArmed    (latchArmed)
  );

  cap_cmp_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busSel       (busSel),
    .busWdata     (busWdata),
    .counterValue (counterValue),
    .busRdata     (busRdata),
    .liveVal      (chanValue),
    .wrBufVal     (wrBufVal)
  );
endmodule

// File: rtl/cap_cmp_reg_chk.sv
module cap_cmp_reg_chk
  import cap_cmp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                captureMode,
  input logic                captureStrobe,
  input logic [2*BYTE_W-1:0] counterValue,
  input logic                busWr,
  input logic                ctrlWr,
  input logic                dbgHalt,
  input logic [2*BYTE_W-1:0] chanValue,
  input logic                latchArmed,
  input chanStrobes_t        strb,
  input logic [2*BYTE_W-1:0] wrBufVal
);
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    captureMode && captureStrobe |=> chanValue == $past(counterValue)); // R2

  AST_SNAPSHOT_IN_CAPTURE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchArmed) |-> $past(captureMode) && !$past(dbgHalt)); // R3

  AST_CTRL_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !latchArmed); // R5

  AST_CAPMODE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    captureMode && busWr && !captureStrobe |=> $stable(chanValue)); // R6

  AST_DBG_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    dbgHalt && !ctrlWr |=> $stable(latchArmed)); // R7

  AST_WRITE_STAGED: assert property (@(posedge clk) disable iff (!rstN)
    !captureMode && !strb.commit |=> $stable(chanValue)); // R9

  AST_COMMIT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> chanValue == $past(wrBufVal)); // R10
endmodule

bind cap_cmp_reg cap_cmp_reg_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .captureMode   (captureMode),
  .captureStrobe (captureStrobe),
  .counterValue  (counterValue),
  .busWr         (busWr),
  .ctrlWr        (ctrlWr),
  .dbgHalt       (dbgHalt),
  .chanValue     (chanValue),
  .latchArmed    (latchArmed),
  .strb          (strb),
  .wrBufVal      (wrBufVal)
);

// File: tb/cap_cmp_reg_test.sv
module cap_cmp_reg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        captureMode = 1'b1;
  logic        captureStrobe = 1'b0;
  logic [15:0] counterValue = '0;
  logic        busSel = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        ctrlWr = 1'b0;
  logic        dbgHalt = 1'b0;
  logic        loadEn = 1'b0;
  logic [15:0] chanValue;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cap_cmp_reg uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic rdByte(input logic sel, output logic [7:0] d);
    @(negedge clk);
    busRd = 1'b1; busSel = sel;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 1'b0;
  endtask

  task automatic rdCheck(input logic sel, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rdByte(sel, d);
    chk(d === exp, tag, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic capture(input logic [15:0] v);
    @(negedge clk);
    captureStrobe = 1'b1; counterValue = v;
    @(posedge clk); #1 captureStrobe = 1'b0;
  endtask

  task automatic wrByte(input logic sel, input logic [7:0] v);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busWdata = v;
    @(posedge clk); #1 busWr = 1'b0;
  endtask

  task automatic pulseLoad();
    @(negedge clk); loadEn = 1'b1;
    @(posedge clk); #1 loadEn = 1'b0;
  endtask

  task automatic pulseCtrl();
    @(negedge clk); ctrlWr = 1'b1;
    @(posedge clk); #1 ctrlWr = 1'b0;
  endtask

  task automatic checkValue(input logic [15:0] exp, input string tag);
    @(negedge clk);
    chk(chanValue === exp, tag, chanValue, exp);
  endtask

  task automatic testReset();
    captureMode = 1'b0;
    checkValue(16'h0000, "R1 reset value");
    rdCheck(1'b1, 8'h00, "R1 reset high byte");
    rdCheck(1'b0, 8'h00, "R1 reset low byte");
    captureMode = 1'b1;
    rdCheck(1'b1, 8'h00, "R1 reset snapshot high");
    rdCheck(1'b0, 8'h00, "R1 reset snapshot low");
  endtask

  task automatic testCapture();
    capture(16'h1234);
    checkValue(16'h1234, "R2 capture loads counter");
  endtask

  task automatic testLowThenHigh();
    rdCheck(1'b0, 8'h34, "R3 lo-first returns live low");
    capture(16'hABCD);
    checkValue(16'hABCD, "R4 capture while held updates live");
    rdCheck(1'b1, 8'h12, "R3 lo-then-hi returns pre-capture high");
    rdCheck(1'b0, 8'hCD, "R3 released, fresh low");
    rdCheck(1'b1, 8'hAB, "R3 fresh high");
  endtask

  task automatic testHighThenLow();
    rdCheck(1'b1, 8'hAB, "R3 hi-first returns live high");
    capture(16'h5E61);
    rdCheck(1'b1, 8'hAB, "R3 repeated first byte stays held");
    capture(16'h7788);
    rdCheck(1'b0, 8'hCD, "R4 hi-then-lo returns pre-capture low");
    rdCheck(1'b1, 8'h77, "R3 released after hi-then-lo");
    rdCheck(1'b0, 8'h88, "R3 second byte of fresh pair");
  endtask

  task automatic testCtrlRelease();
    rdCheck(1'b1, 8'h77, "R3 arm before control write");
    capture(16'h4321);
    pulseCtrl();
    rdCheck(1'b0, 8'h21, "R5 control write released snapshot");
    rdCheck(1'b1, 8'h43, "R5 pair after release");
    // control write and read in the same cycle
    @(negedge clk);
    busRd = 1'b1; busSel = 1'b1; ctrlWr = 1'b1;
    @(posedge clk); #1 busRd = 1'b0; ctrlWr = 1'b0;
    capture(16'h9ABC);
    rdCheck(1'b0, 8'hBC, "R5 control write wins over same-cycle read");
    rdCheck(1'b1, 8'h9A, "R5 pair after same-cycle case");
    // control write during debug halt
    rdCheck(1'b0, 8'hBC, "R5 arm before halt");
    capture(16'h0F1E);
    @(negedge clk); dbgHalt = 1'b1;
    pulseCtrl();
    @(negedge clk); dbgHalt = 1'b0;
    rdCheck(1'b1, 8'h0F, "R5 control write in halt released snapshot");
    rdCheck(1'b0, 8'h1E, "R5 pair after halt release");
  endtask

  task automatic testCaptureWriteIgnored();
    wrByte(1'b1, 8'hFF);
    wrByte(1'b0, 8'hEE);
    pulseLoad();
    checkValue(16'h0F1E, "R6 capture-mode writes ignored");
  endtask

  task automatic testDebug();
    rdCheck(1'b0, 8'h1E, "R3 arm before halt entry");
    capture(16'hC0DE);
    @(negedge clk); dbgHalt = 1'b1;
    rdCheck(1'b1, 8'hC0, "R8 halt read high bypasses snapshot");
    rdCheck(1'b0, 8'hDE, "R8 halt read low bypasses snapshot");
    @(negedge clk); dbgHalt = 1'b0;
    rdCheck(1'b1, 8'h0F, "R7 snapshot survives halt");
    rdCheck(1'b0, 8'hDE, "R7 released after halt completion");
    rdCheck(1'b1, 8'hC0, "R7 pair closes");
    // reads in halt must not take a snapshot
    @(negedge clk); dbgHalt = 1'b1;
    rdCheck(1'b1, 8'hC0, "R8 halt read while idle");
    @(negedge clk); dbgHalt = 1'b0;
    capture(16'h2468);
    rdCheck(1'b0, 8'h68, "R7 halt read did not arm");
    rdCheck(1'b1, 8'h24, "R7 pair after halt");
  endtask

  task automatic testCompare();
    captureMode = 1'b0;
    wrByte(1'b1, 8'h77);
    checkValue(16'h2468, "R9 staged high not live");
    pulseLoad();
    checkValue(16'h2468, "R10 commit with one byte ignored");
    wrByte(1'b0, 8'h88);
    checkValue(16'h2468, "R9 staged low not live");
    pulseLoad();
    checkValue(16'h7788, "R10 hi-then-lo commit");
    wrByte(1'b0, 8'h22);
    pulseLoad();
    checkValue(16'h7788, "R10 low alone not committed");
    wrByte(1'b1, 8'h11);
    pulseLoad();
    checkValue(16'h1122, "R10 lo-then-hi commit");
    rdCheck(1'b1, 8'h11, "R11 compare read high");
    wrByte(1'b1, 8'h33);
    wrByte(1'b0, 8'h44);
    pulseLoad();
    rdCheck(1'b0, 8'h44, "R11 compare read low is live, no snapshot");
    rdCheck(1'b1, 8'h33, "R11 compare read high is live");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCapture();
    testLowThenHigh();
    testHighThenLow();
    testCtrlRelease();
    testCaptureWriteIgnored();
    testDebug();
    testCompare();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog expired actual=0x0000 expected=0x0001");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule